// File: doc/BRIEF.md
# Shifted-Immediate Accumulator Subtract Unit

This block holds a 32-bit accumulator and a small set of status flags. It applies one operation to them: subtract a 16-bit constant that has been shifted left. Each operation is described by two 16-bit words. The first word is an opcode pattern that carries a 4-bit shift count. The second word is the constant itself.

Two mode inputs control the operation.
- The extension mode chooses whether the constant is sign- or zero-extended before it is shifted.
- The saturation mode chooses what happens on a signed overflow. The result is either clamped to the nearest signed limit, or allowed to wrap while a 6-bit up/down overflow counter records the event.

Every subtraction falls into one of three overflow classes: `OVF_NONE`, `OVF_POS` or `OVF_NEG`. The result, V and counter logic branches on that class, and the result is committed on a clock edge where the execute strobe is high and the opcode matches.

Top module: `shimm_acc_sub`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears the accumulator, Z, N, C, V and the overflow counter to zero.
- R2: An execute strobe changes no output unless bits [15:4] of `op_word` equal 0xFF0. With any other value, every output keeps its value.
- R3: The shift count is `op_word[3:0]`. The constant `imm_word` is first extended to 32 bits, by copying bit 15 when `sext_mode`=1 or with zeros when it is 0. It is then shifted left by that count. Vacated low bits are zero and bits moved above bit 31 are discarded.
- R4: On an accepted operation the accumulator becomes accumulator minus the R3 operand, taken modulo 2^32 when no saturation applies.
- R5: Z is 1 exactly when the value written to the accumulator is zero. N equals bit 31 of that written value, including after saturation.
- R6: C is 0 when the operand, taken as unsigned, exceeds the previous accumulator, taken as unsigned (a borrow). Otherwise C is 1.
- R7: V becomes 1 when the signed subtraction overflows. Otherwise V keeps its value. Only reset clears it.
- R8: With `sat_mode`=0, a positive overflow adds 1 to the 6-bit counter and a negative overflow subtracts 1. The counter wraps: 63 + 1 = 0 and 0 − 1 = 63.
- R9: With `sat_mode`=1, a positive overflow writes 0x7FFFFFFF, a negative overflow writes 0x80000000, and the counter does not change.
- R10: With the execute strobe low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec | input | 1 | Execute strobe |
| op_word | input | 16 | First instruction word: opcode pattern and shift count |
| imm_word | input | 16 | Second instruction word: 16-bit constant |
| sext_mode | input | 1 | 1 = sign-extend the constant, 0 = zero-extend it |
| sat_mode | input | 1 | 1 = saturate on overflow, 0 = wrap and count |
| acc_q | output | 32 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag (inverted borrow) |
| flag_v | output | 1 | Sticky overflow flag |
| ovf_cnt | output | 6 | Overflow counter |

## Verification
The bench drives a sequence of subtractions that walk the accumulator across both signed limits, in both modes, and compares every output after each one.

It targets the following corner cases:
- A 0x8000 constant shifted by 15 with sign extension. A design that extends after shifting produces a positive operand.
- A 0xFFFF constant, which shows whether the operand is zero-extended or sign-extended.
- Subtracting from zero. This exposes a carry flag that is not inverted.
- An overflow with the saturation mode set. A design that checks N or Z before clamping reports the wrong sign.
- Counter wrap from 0 down to 63, and V staying set after non-overflowing steps.

Mismatched opcodes and idle cycles are also checked to leave every output untouched.

// File: rtl/shimm_pkg.sv
package shimm_pkg;
    localparam int ACC_W   = 32;
    localparam int IMM_W   = 16;
    localparam int SHF_W   = 4;
    localparam int CNT_W   = 6;
    localparam int OPC_W   = 16 - SHF_W;
    localparam logic [OPC_W-1:0] OPC_MATCH = 12'hFF0;

    typedef enum logic [1:0] {
        OVF_NONE = 2'd0,
        OVF_POS  = 2'd1,
        OVF_NEG  = 2'd2
    } ovf_kind_t;
endpackage

// File: rtl/shimm_decode.sv
module shimm_decode
    import shimm_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SH_W   = SHF_W
) (
    input  logic [WORD_W-1:0] op_word,
    output logic              hit,
    output logic [SH_W-1:0]   shamt
);
    localparam int PFX_W = WORD_W - SH_W;

    always_comb begin
        hit   = (op_word[WORD_W-1:SH_W] == PFX_W'(OPC_MATCH));
        shamt = op_word[SH_W-1:0];
    end
endmodule

// File: rtl/shimm_operand.sv
module shimm_operand
    import shimm_pkg::*;
#(
    parameter int IW   = IMM_W,
    parameter int AW   = ACC_W,
    parameter int SH_W = SHF_W
) (
    input  logic [IW-1:0]   imm,
    input  logic            sext,
    input  logic [SH_W-1:0] shamt,
    output logic [AW-1:0]   opnd
);
    localparam int PAD_W = AW - IW;

    logic [AW-1:0] ext;

    always_comb begin
        ext  = sext ? {{PAD_W{imm[IW-1]}}, imm} : {{PAD_W{1'b0}}, imm};
        opnd = ext << shamt;
    end
endmodule

// File: rtl/shimm_subtract.sv
module shimm_subtract
    import shimm_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] opnd,
    output logic [AW-1:0] diff,
    output logic          borrow,
    output ovf_kind_t     kind
);
    logic [AW:0] wide;

    always_comb begin
        wide   = {acc[AW-1], acc} - {opnd[AW-1], opnd};
        diff   = wide[AW-1:0];
        borrow = (acc < opnd);
        unique case ({wide[AW], wide[AW-1]})
            2'b01:   kind = OVF_POS;
            2'b10:   kind = OVF_NEG;
            default: kind = OVF_NONE;
        endcase
    end
endmodule

// File: rtl/shimm_acc_sub.sv
module shimm_acc_sub
    import shimm_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int IW = IMM_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec,
    input  logic [15:0]   op_word,
    input  logic [IW-1:0] imm_word,
    input  logic          sext_mode,
    input  logic          sat_mode,
    output logic [AW-1:0] acc_q,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_c,
    output logic          flag_v,
    output logic [CW-1:0] ovf_cnt
);
    localparam logic [AW-1:0] MAX_POS = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] MAX_NEG = {1'b1, {(AW-1){1'b0}}};

    logic            hit;
    logic [SHF_W-1:0] shamt;
    logic [AW-1:0]   opnd;
    logic [AW-1:0]   diff;
    logic            borrow;
    ovf_kind_t       kind;
    logic            go;

    logic [AW-1:0]   res;
    logic [CW-1:0]   cnt_nx;
    logic            v_nx;

    shimm_decode #(.WORD_W(16), .SH_W(SHF_W)) u_dec (
        .op_word (op_word),
        .hit     (hit),
        .shamt   (shamt)
    );

    shimm_operand #(.IW(IW), .AW(AW), .SH_W(SHF_W)) u_opnd (
        .imm   (imm_word),
        .sext  (sext_mode),
        .shamt (shamt),
        .opnd  (opnd)
    );

    shimm_subtract #(.AW(AW)) u_sub (
        .acc    (acc_q),
        .opnd   (opnd),
        .diff   (diff),
        .borrow (borrow),
        .kind   (kind)
    );

    assign go = exec && hit;

    // Result selection per overflow class
    always_comb begin
        res    = diff;
        cnt_nx = ovf_cnt;
        v_nx   = flag_v;
        unique case (kind)
            OVF_NONE: ;
            OVF_POS: begin
                v_nx = 1'b1;
                if (sat_mode) res    = MAX_POS;
                else          cnt_nx = ovf_cnt + CW'(1);
            end
            OVF_NEG: begin
                v_nx = 1'b1;
                if (sat_mode) res    = MAX_NEG;
                else          cnt_nx = ovf_cnt - CW'(1);
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flag_z  <= 1'b0;
            flag_n  <= 1'b0;
            flag_c  <= 1'b0;
            flag_v  <= 1'b0;
            ovf_cnt <= '0;
        end else if (go) begin
            acc_q   <= res;
            flag_z  <= (res == '0);
            flag_n  <= res[AW-1];
            flag_c  <= ~borrow;
            flag_v  <= v_nx;
            ovf_cnt <= cnt_nx;
        end
    end

    // R7
    v_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |=> flag_v);

    // R9
    sat_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sat_mode) |=> $stable(ovf_cnt));

    // R9
    sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sat_mode && kind == OVF_POS) |=> (acc_q == MAX_POS));

    // R9
    sat_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sat_mode && kind == OVF_NEG) |=> (acc_q == MAX_NEG));

    // R8
    cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !sat_mode && kind == OVF_POS) |=> (ovf_cnt == CW'($past(ovf_cnt) + CW'(1))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> ($stable(acc_q) && $stable(ovf_cnt) && $stable(flag_c)));

    // R2
    opc_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !hit) |=> ($stable(acc_q) && $stable(flag_v)));
endmodule

// File: tb/shimm_acc_sub_tb.sv
module shimm_acc_sub_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    // {op_word, imm_word, sext_mode, sat_mode}
    localparam logic [33:0] VEC [NV] = '{
        {16'hFF00, 16'h0001, 1'b0, 1'b0},
        {16'hFF04, 16'h0010, 1'b1, 1'b0},
        {16'hFF0F, 16'h8000, 1'b1, 1'b0},
        {16'hFF0F, 16'h7FFF, 1'b0, 1'b0},
        {16'hFF0F, 16'h8000, 1'b1, 1'b0},
        {16'hFF0F, 16'h8000, 1'b1, 1'b0},
        {16'hFF00, 16'h0001, 1'b0, 1'b0},
        {16'hFF0F, 16'h4000, 1'b0, 1'b0},
        {16'hFF0F, 16'h4000, 1'b0, 1'b1},
        {16'hFF0F, 16'h8000, 1'b1, 1'b1},
        {16'hFF0F, 16'hFFFF, 1'b0, 1'b0},
        {16'hFF00, 16'h7FFF, 1'b0, 1'b0},
        {16'hFF10, 16'h1234, 1'b1, 1'b0},
        {16'hFF00, 16'hFFFF, 1'b1, 1'b0},
        {16'hFF00, 16'hFFFF, 1'b0, 1'b0},
        {16'hFF0F, 16'h4000, 1'b0, 1'b1},
        {16'hFF0F, 16'h4000, 1'b0, 1'b1},
        {16'hFF0F, 16'h4000, 1'b0, 1'b1},
        {16'hFF0F, 16'h4000, 1'b0, 1'b1},
        {16'hFF00, 16'h0001, 1'b0, 1'b0},
        {16'h0F00, 16'h0005, 1'b0, 1'b0},
        {16'hFF03, 16'hFFF8, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec = 1'b0;
    logic [15:0] op_word = '0;
    logic [15:0] imm_word = '0;
    logic        sext_mode = 1'b0;
    logic        sat_mode = 1'b0;
    logic [31:0] acc_q;
    logic        flag_z, flag_n, flag_c, flag_v;
    logic [5:0]  ovf_cnt;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_acc;
    logic        m_z, m_n, m_c, m_v;
    logic [5:0]  m_cnt;

    shimm_acc_sub u_dut (
        .clk (clk), .rst_n (rst_n), .exec (exec),
        .op_word (op_word), .imm_word (imm_word),
        .sext_mode (sext_mode), .sat_mode (sat_mode),
        .acc_q (acc_q), .flag_z (flag_z), .flag_n (flag_n),
        .flag_c (flag_c), .flag_v (flag_v), .ovf_cnt (ovf_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string acc_tag);
        chk(acc_tag, acc_q, m_acc);
        chk("R5 Z", 32'(flag_z), 32'(m_z));
        chk("R5 N", 32'(flag_n), 32'(m_n));
        chk("R6 C", 32'(flag_c), 32'(m_c));
        chk("R7 V", 32'(flag_v), 32'(m_v));
        chk("R8 cnt", 32'(ovf_cnt), 32'(m_cnt));
    endtask

    // Reference: apply one operation to the model state
    task automatic model_step(input logic [15:0] ow, input logic [15:0] iw,
                              input logic sx, input logic sm, output string tag);
        logic [31:0] ext, op;
        longint      tru;
        tag = "R3 R4 acc";
        if (ow[15:4] != 12'hFF0) begin
            tag = "R2 acc";
            return;
        end
        ext = sx ? {{16{iw[15]}}, iw} : {16'h0000, iw};
        op  = ext << ow[3:0];
        tru = longint'($signed(m_acc)) - longint'($signed(op));
        m_c = (op > m_acc) ? 1'b0 : 1'b1;
        if (tru > 64'sd2147483647) begin
            m_v = 1'b1;
            if (sm) begin m_acc = 32'h7FFFFFFF; tag = "R9 acc"; end
            else begin m_acc = tru[31:0]; m_cnt = m_cnt + 6'd1; end
        end else if (tru < -64'sd2147483648) begin
            m_v = 1'b1;
            if (sm) begin m_acc = 32'h80000000; tag = "R9 acc"; end
            else begin m_acc = tru[31:0]; m_cnt = m_cnt - 6'd1; end
        end else begin
            m_acc = tru[31:0];
        end
        m_z = (m_acc == 32'h0);
        m_n = m_acc[31];
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        string tag;
        m_acc = '0; m_z = 0; m_n = 0; m_c = 0; m_v = 0; m_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1 acc");

        for (int i = 0; i < NV; i++) begin
            op_word   = VEC[i][33:18];
            imm_word  = VEC[i][17:2];
            sext_mode = VEC[i][1];
            sat_mode  = VEC[i][0];
            exec      = 1'b1;
            model_step(op_word, imm_word, sext_mode, sat_mode, tag);
            @(negedge clk);
            exec = 1'b0;
            check_all(tag);
        end

        // R10: strobe low, matching opcode present, nothing moves
        op_word = 16'hFF00; imm_word = 16'h0001; sat_mode = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R10 acc");

        // R1: mid-run reset clears everything, including sticky V
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0; m_z = 0; m_n = 0; m_c = 0; m_v = 0; m_cnt = '0;
        check_all("R1 acc");

        // R6: subtract zero from zero gives no borrow, Z set
        op_word = 16'hFF05; imm_word = 16'h0000; sext_mode = 1'b1; exec = 1'b1;
        model_step(op_word, imm_word, sext_mode, sat_mode, tag);
        @(negedge clk);
        exec = 1'b0;
        check_all(tag);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule